// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block brings a stuck two-wire serial bus back to idle. A target device that lost sync in the middle of a byte may keep holding the data line low. When asked to recover, the sequencer first releases both lines. It then toggles the clock line a fixed number of times (nine by default) and notes whether the data line was seen high after any rising clock edge. It always finishes every clock pulse, so that any target still in the middle of a byte shifts out the rest of it.

If the data line was ever seen high, the block makes a START and a STOP condition with the clock line held high the whole time. It then waits out the bus-free interval and reports success. If the data line never went high, it reports a wedged bus and makes no START.

Both lines follow an open-drain model. An output enable pulls its line low; a released line floats high. All timing comes from a microsecond tick derived from the system clock. Each release of the clock line waits for a target that stretches the clock, up to a timeout.

Top module: `bus_recovery_seq`

## Requirements
- R1: After reset and while idle (busy low), scl_oe, sda_oe, busy and done are all 0 and both lines are released.
- R2: A recovery pulls the clock line low exactly NUM_PULSES times (9 by default). Each low phase lasts LOW_US microseconds (2 µs, 100 to 102 cycles at 50 MHz).
- R3: All NUM_PULSES clock pulses are issued even when the data line is seen high after an early pulse.
- R4: bus_ok is 1 with done if and only if the synchronized data line was high at the sample taken when the clock line was seen high in at least one pulse.
- R5: On the success path, sda_oe is asserted for one START/STOP pair. scl_oe stays 0 throughout, so the data line falls and rises with the clock line high.
- R6: On the success path, done arrives at least BUF_US microseconds (60 µs, 3000 cycles) after sda_oe is released.
- R7: On the failure path (data never seen high), sda_oe is never asserted and done follows the last pulse with bus_ok = 0.
- R8: pins_warn is 1 with done when, on the success path, the clock line or the data line is low just before the START. It is 0 otherwise.
- R9: After each release of the clock line the block waits for the line to read high. A stretch shorter than STRETCH_US (1000 µs) leaves stretch_tmo at 0. A longer stretch sets stretch_tmo to 1, and the sequence carries on.
- R10: recover_req is ignored while busy: a recovery yields exactly one done pulse, and busy falls the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_req | input | 1 | Start a recovery (accepted only while idle) |
| scl_i | input | 1 | Clock line as read from the pad |
| sda_i | input | 1 | Data line as read from the pad |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | A recovery is in progress |
| done | output | 1 | One-cycle pulse at the end of a recovery |
| bus_ok | output | 1 | Result: data line seen high, bus freed |
| pins_warn | output | 1 | Lines were not both high just before the START |
| stretch_tmo | output | 1 | At least one clock release timed out |

## Verification
The bench runs the sequence against a simulated target with six data-line and clock-line behaviours. In the first, data is held low forever, which separates the failure path from the success path. In the second, data is released after the fourth pulse, which shows that clocking does not stop early. In the third, data is free throughout. The fourth releases data only around the fifth pulse and then holds it low again, which yields success together with the pins warning. The last two stretch the clock for 10 µs and for 1100 µs, which tells a tolerated stretch apart from a timeout that still lets the sequence finish. A second request in the middle of the free-bus run checks that requests are ignored while busy.

// File: rtl/bus_rcv_pkg.sv
package bus_rcv_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RELEASE,
      ST_LOW,
      ST_RISE,
      ST_HIGH,
      ST_CHECK,
      ST_SETUP,
      ST_START,
      ST_BUF,
      ST_DONE
   } rcv_state_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rcv_pin_sync.sv
module rcv_pin_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign pin_out = pin_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
            end else begin
               stage_q[0] <= pin_in;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign pin_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rcv_us_timer.sv
module rcv_us_timer #(
   parameter int CYCLES_PER_US = 50,
   parameter int MAX_US        = 1000,
   localparam int CYC_W        = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1,
   localparam int US_W         = $clog2(MAX_US + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   output logic [US_W-1:0] us_cnt
);

   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLES_PER_US - 1);
   localparam logic [US_W-1:0]  US_SAT   = US_W'(MAX_US);

   logic [CYC_W-1:0] cyc_q;
   logic             tick;

   assign tick = (cyc_q == CYC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         us_cnt <= '0;
      end else if (clr) begin
         cyc_q  <= '0;
         us_cnt <= '0;
      end else begin
         cyc_q <= tick ? '0 : cyc_q + 1'b1;
         if (tick && us_cnt != US_SAT) us_cnt <= us_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rcv_line_track.sv
module rcv_line_track (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic sample,
   input  logic timeout,
   input  logic check,
   input  logic scl_s,
   input  logic sda_s,
   output logic seen_high,
   output logic warn,
   output logic tmo
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_high <= 1'b0;
         warn      <= 1'b0;
         tmo       <= 1'b0;
      end else if (clr) begin
         seen_high <= 1'b0;
         warn      <= 1'b0;
         tmo       <= 1'b0;
      end else begin
         if (sample && sda_s)     seen_high <= 1'b1;
         if (timeout)             tmo       <= 1'b1;
         if (check && seen_high)  warn      <= !(scl_s && sda_s);
      end
   end

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq #(
   parameter int CYCLES_PER_US = 50,
   parameter int NUM_PULSES    = 9,
   parameter int ENTRY_US      = 1,
   parameter int LOW_US        = 2,
   parameter int HIGH_US       = 2,
   parameter int SETUP_US      = 1,
   parameter int HOLD_US       = 1,
   parameter int BUF_US        = 60,
   parameter int STRETCH_US    = 1000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic recover_req,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_oe,
   output logic sda_oe,
   output logic busy,
   output logic done,
   output logic bus_ok,
   output logic pins_warn,
   output logic stretch_tmo
);
   import bus_rcv_pkg::*;

   localparam int MAX_US = int'(max_of(max_of(max_of(STRETCH_US, BUF_US),
                                               max_of(LOW_US, HIGH_US)),
                                        max_of(max_of(SETUP_US, HOLD_US), ENTRY_US)));
   localparam int US_W   = $clog2(MAX_US + 1);
   localparam int PC_W   = $clog2(NUM_PULSES + 1);

   localparam logic [US_W-1:0] T_ENTRY   = US_W'(ENTRY_US);
   localparam logic [US_W-1:0] T_LOW     = US_W'(LOW_US);
   localparam logic [US_W-1:0] T_HIGH    = US_W'(HIGH_US);
   localparam logic [US_W-1:0] T_SETUP   = US_W'(SETUP_US);
   localparam logic [US_W-1:0] T_HOLD    = US_W'(HOLD_US);
   localparam logic [US_W-1:0] T_BUF     = US_W'(BUF_US);
   localparam logic [US_W-1:0] T_STRETCH = US_W'(STRETCH_US);
   localparam logic [PC_W-1:0] LAST_PULSE = PC_W'(NUM_PULSES - 1);

   generate
      if (NUM_PULSES < 1) begin : g_bad_pulses
         $error("NUM_PULSES must be at least 1");
      end
      if (CYCLES_PER_US < 2) begin : g_bad_clock
         $error("CYCLES_PER_US must be at least 2");
      end
      if (LOW_US < 1 || HIGH_US < 1 || STRETCH_US < 1 || BUF_US < 1) begin : g_bad_timing
         $error("all phase durations must be at least 1 us");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
   endgenerate

   rcv_state_e      state_q, state_d;
   logic [US_W-1:0] us_cnt;
   logic [PC_W-1:0] pulse_q;
   logic [1:0]      pins_s;
   logic            scl_s, sda_s;
   logic            seen_high;
   logic            req_take, sample_now, tmo_now, check_now, last_pulse;

   rcv_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in ({scl_i, sda_i}),
      .pin_out(pins_s)
   );
   assign scl_s = pins_s[1];
   assign sda_s = pins_s[0];

   rcv_us_timer #(.CYCLES_PER_US(CYCLES_PER_US), .MAX_US(MAX_US)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_d != state_q),
      .us_cnt(us_cnt)
   );

   assign last_pulse = (pulse_q == LAST_PULSE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (recover_req)            state_d = ST_RELEASE;
         ST_RELEASE: if (us_cnt >= T_ENTRY)      state_d = ST_LOW;
         ST_LOW:     if (us_cnt >= T_LOW)        state_d = ST_RISE;
         ST_RISE:    if (scl_s || us_cnt >= T_STRETCH) state_d = ST_HIGH;
         ST_HIGH:    if (us_cnt >= T_HIGH)       state_d = last_pulse ? ST_CHECK : ST_LOW;
         ST_CHECK:                               state_d = seen_high ? ST_SETUP : ST_DONE;
         ST_SETUP:   if (us_cnt >= T_SETUP)      state_d = ST_START;
         ST_START:   if (us_cnt >= T_HOLD)       state_d = ST_BUF;
         ST_BUF:     if (us_cnt >= T_BUF)        state_d = ST_DONE;
         ST_DONE:                                state_d = ST_IDLE;
         default:                                state_d = ST_IDLE;
      endcase
   end

   assign req_take   = (state_q == ST_IDLE) && recover_req;
   assign sample_now = (state_q == ST_RISE) && (state_d == ST_HIGH);
   assign tmo_now    = (state_q == ST_RISE) && !scl_s && (us_cnt >= T_STRETCH);
   assign check_now  = (state_q == ST_CHECK);

   rcv_line_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (req_take),
      .sample   (sample_now),
      .timeout  (tmo_now),
      .check    (check_now),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .seen_high(seen_high),
      .warn     (pins_warn),
      .tmo      (stretch_tmo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pulse_q <= '0;
         bus_ok  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RELEASE)
            pulse_q <= '0;
         else if (state_q == ST_HIGH && state_d == ST_LOW)
            pulse_q <= pulse_q + 1'b1;
         if (req_take)
            bus_ok <= 1'b0;
         else if (state_q != ST_DONE && state_d == ST_DONE)
            bus_ok <= seen_high;
      end
   end

   assign scl_oe = (state_q == ST_LOW);
   assign sda_oe = (state_q == ST_START);
   assign busy   = (state_q != ST_IDLE);
   assign done   = (state_q == ST_DONE);

endmodule

// File: rtl/bus_recovery_seq_chk.sv
module bus_recovery_seq_chk #(
   parameter int CYCLES_PER_US = 50,
   parameter int NUM_PULSES    = 9,
   parameter int BUF_US        = 60
) (
   input logic clk,
   input logic rst_n,
   input logic recover_req,
   input logic scl_oe,
   input logic sda_oe,
   input logic busy,
   input logic done,
   input logic bus_ok
);

   localparam int BUF_CYC = BUF_US * CYCLES_PER_US;
   localparam int BC_W    = $clog2(BUF_CYC + 2);
   localparam int PC_W    = $clog2(NUM_PULSES + 2);

   logic            busy_q, scl_q, sda_q, sda_used;
   logic [PC_W-1:0] pulse_cnt;
   logic [BC_W-1:0] buf_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         scl_q     <= 1'b0;
         sda_q     <= 1'b0;
         sda_used  <= 1'b0;
         pulse_cnt <= '0;
         buf_cnt   <= '0;
      end else begin
         busy_q <= busy;
         scl_q  <= scl_oe;
         sda_q  <= sda_oe;
         if (busy && !busy_q) begin
            pulse_cnt <= '0;
            sda_used  <= 1'b0;
         end else begin
            if (scl_oe && !scl_q && pulse_cnt != '1) pulse_cnt <= pulse_cnt + 1'b1;
            if (sda_oe) sda_used <= 1'b1;
         end
         if (!sda_oe && sda_q) buf_cnt <= '0;
         else if (buf_cnt != '1) buf_cnt <= buf_cnt + 1'b1;
      end
   end

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe && !done));

   // R5
   start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> !scl_oe);

   // R2
   pulse_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pulse_cnt == PC_W'(NUM_PULSES)));

   // R7
   fail_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !bus_ok) |-> !sda_used);

   // R4
   ok_has_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bus_ok) |-> sda_used);

   // R6
   buf_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bus_ok) |-> (buf_cnt >= BC_W'(BUF_CYC)));

   // R10
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R10
   start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(recover_req));

endmodule

bind bus_recovery_seq bus_recovery_seq_chk #(
   .CYCLES_PER_US(CYCLES_PER_US),
   .NUM_PULSES   (NUM_PULSES),
   .BUF_US       (BUF_US)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .recover_req(recover_req),
   .scl_oe     (scl_oe),
   .sda_oe     (sda_oe),
   .busy       (busy),
   .done       (done),
   .bus_ok     (bus_ok)
);

// File: tb/bus_recovery_seq_test.sv
module bus_recovery_seq_test;

   typedef struct packed {
      logic ok;
      logic warn;
      logic tmo;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic recover_req = 1'b0;
   logic scl_oe, sda_oe, busy, done, bus_ok, pins_warn, stretch_tmo;
   logic scl_line, sda_line, scl_hold, sda_hold;

   int checks = 0;
   int errors = 0;
   int mode = 2;
   int rise_cnt, pulses, low_len, low_min, low_max, done_cnt, since_rel, stretch_left, oe_rises;
   bit sda_used, start_bad, scl_prev, line_prev, sda_prev;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   assign scl_hold = (stretch_left > 0);
   assign sda_hold = (mode == 0) ? 1'b1 :
                     (mode == 1) ? (rise_cnt < 4) :
                     (mode == 3) ? (rise_cnt < 4 || rise_cnt > 5) : 1'b0;
   assign scl_line = !scl_oe && !scl_hold;
   assign sda_line = !sda_oe && !sda_hold;

   bus_recovery_seq uut (
      .clk(clk), .rst_n(rst_n), .recover_req(recover_req),
      .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
      .bus_ok(bus_ok), .pins_warn(pins_warn), .stretch_tmo(stretch_tmo)
   );

   task automatic check(input string req, input int act, input int exp, input bit pass);
      checks++;
      if (!pass) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor and target model
   always @(negedge clk) begin
      if (scl_oe && !scl_prev) begin
         pulses++;
         oe_rises++;
         low_len = 0;
         if (oe_rises == 3 && mode == 4) stretch_left = 101 + 500;
         if (oe_rises == 3 && mode == 5) stretch_left = 101 + 55000;
      end
      if (scl_oe) low_len++;
      if (!scl_oe && scl_prev) begin
         if (low_len < low_min) low_min = low_len;
         if (low_len > low_max) low_max = low_len;
      end
      if (scl_line && !line_prev) rise_cnt++;
      if (sda_oe) sda_used = 1;
      if (sda_oe && scl_oe) start_bad = 1;
      if (!sda_oe && sda_prev) since_rel = 0;
      else since_rel++;
      if (done) begin
         exp_t e;
         done_cnt++;
         if (exp_q.size() == 0) begin
            check("R10 unexpected done", 1, 0, 1'b0);
         end else begin
            e = exp_q.pop_front();
            check("R4 bus_ok", int'(bus_ok), int'(e.ok), bus_ok == e.ok);
            check("R8 pins_warn", int'(pins_warn), int'(e.warn), pins_warn == e.warn);
            check("R9 stretch_tmo", int'(stretch_tmo), int'(e.tmo), stretch_tmo == e.tmo);
            if (e.ok)
               check("R6 bus-free wait", since_rel, 3000, since_rel >= 3000);
         end
      end
      if (stretch_left > 0) stretch_left--;
      scl_prev  = scl_oe;
      line_prev = scl_line;
      sda_prev  = sda_oe;
   end

   task automatic run_case(input int m, input bit eok, input bit ewarn, input bit etmo,
                           input bit extra_req);
      exp_t e;
      int guard;
      @(negedge clk);
      mode = m;
      rise_cnt = 0; pulses = 0; oe_rises = 0; done_cnt = 0;
      low_min = 1 << 30; low_max = 0;
      sda_used = 0; start_bad = 0; since_rel = 0;
      e.ok = eok; e.warn = ewarn; e.tmo = etmo;
      exp_q.push_back(e);
      recover_req = 1'b1;
      @(negedge clk);
      recover_req = 1'b0;
      if (extra_req) begin
         repeat (1500) @(negedge clk);
         recover_req = 1'b1;
         @(negedge clk);
         recover_req = 1'b0;
      end
      guard = 0;
      while (done_cnt == 0 && guard < 80000) begin
         @(negedge clk);
         guard++;
      end
      repeat (3000) @(negedge clk);
      check($sformatf("R2 R3 pulse count mode %0d", m), pulses, 9, pulses == 9);
      check("R2 low phase min", low_min, 100, low_min >= 100 && low_min <= 102);
      check("R2 low phase max", low_max, 102, low_max >= 100 && low_max <= 102);
      check("R5 R7 start issued", int'(sda_used), int'(eok), sda_used == eok);
      check("R5 data moved with clock high", int'(start_bad), 0, !start_bad);
      check("R10 single done", done_cnt, 1, done_cnt == 1);
      check("R10 idle after run", int'(busy), 0, !busy);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check("R1 scl_oe reset", int'(scl_oe), 0, !scl_oe);
      check("R1 sda_oe reset", int'(sda_oe), 0, !sda_oe);
      check("R1 busy reset", int'(busy), 0, !busy);
      check("R1 done reset", int'(done), 0, !done);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 idle after reset", int'(scl_oe | sda_oe | busy), 0, !(scl_oe | sda_oe | busy));
      run_case(0, 1'b0, 1'b0, 1'b0, 1'b0);   // R7 wedged data line
      run_case(1, 1'b1, 1'b0, 1'b0, 1'b0);   // R3 data frees after pulse 4
      run_case(2, 1'b1, 1'b0, 1'b0, 1'b1);   // R10 free bus with extra request
      run_case(3, 1'b1, 1'b1, 1'b0, 1'b0);   // R8 data low again before START
      run_case(4, 1'b1, 1'b0, 1'b0, 1'b0);   // R9 short stretch
      run_case(5, 1'b1, 1'b0, 1'b1, 1'b0);   // R9 stretch past timeout
      check("R1 released at end", int'(scl_oe | sda_oe), 0, !(scl_oe | sda_oe));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule